// File: doc/BRIEF.md
# Master-Clock Ratio Detector

This block measures how many master-clock cycles make up one period of the left/right word clock. It then decides which oversampling ratio the system is running at. The block runs in the master-clock domain. The word clock reaches it asynchronously and passes through a synchroniser. The period is counted between successive rising edges of the synchronised word clock. Each measured period is compared against six supported ratios, with a fixed window of plus or minus eight cycles.

A ratio is taken up only when two consecutive periods fall into the same window. This keeps jitter and a single odd period from causing a false detection. The DAC mute, by contrast, is asserted as soon as one period misses every window, or when the word clock stops rising altogether.

A separate watchdog runs on a slow, free-running reference clock. It raises a power-down flag when the master clock has not toggled for a programmable number of reference cycles.

The block has no streaming data path. All of its pins are plain control and status levels, so no valid/ready handshake or back-pressure applies.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is held and just after it is released, `mute` is 1, `locked` is 0, `ratio_code` is 0 and `pwr_down` is 0.
- R2: `ratio_code` encodes the detected ratio in ascending order: 0 for 128, 1 for 192, 2 for 256, 3 for 384, 4 for 512 and 5 for 768 master-clock cycles per word-clock period.
- R3: A period is accepted when it lies at most 8 cycles from a supported ratio. A period 9 or more cycles from every ratio is rejected.
- R4: A single rejected period sets `mute` to 1 and `locked` to 0 within a few master-clock cycles of the word-clock rising edge that closes it. This holds even when the block was locked before.
- R5: `locked` rises, `mute` falls and `ratio_code` changes only when two consecutive measured periods fall into the same ratio window. One accepted period after a mute leaves the block muted.
- R6: Periods that alternate within the tolerance window of a single ratio keep the block locked on that ratio.
- R7: The period counter saturates at 777. If 777 cycles pass with no rising word-clock edge, `mute` is set to 1 and `locked` to 0.
- R8: `locked` and `mute` are never both 1, and `ratio_code` never exceeds 5.
- R9: When the master clock stops, `pwr_down` rises after about `stop_limit` reference-clock cycles. It falls again within a few reference cycles once the master clock resumes. The reference clock must be slower than the master clock and must not be an exact multiple of its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| word_clk | input | 1 | Left/right word clock, asynchronous to mclk |
| ref_clk | input | 1 | Slow free-running reference clock for the stop watchdog |
| stop_limit | input | 16 | Number of reference cycles without a master-clock toggle before power-down |
| ratio_code | output | 3 | Detected ratio code (0..5, ascending ratio) |
| locked | output | 1 | A ratio has been confirmed by two agreeing periods |
| mute | output | 1 | DAC path shut down and output muted |
| pwr_down | output | 1 | Master clock judged stopped |

## Verification
Six ratios are measured:

- **Exact periods of every ratio** show that each window decodes to its own code.
- **Periods exactly 8 cycles off a ratio, and periods 9 cycles off**, separate an inclusive tolerance from an exclusive one, on both the low and the high side.
- **A lone out-of-window period inside a locked stream** shows that mute reacts to one period.
- **A period pattern alternating inside one window** shows that jitter does not break lock.
- **A restart after a stall, checked between the first and second good period**, shows that one agreeing period is not enough to lock.
- **A held word clock** exercises the saturation timeout.
- **A gated master clock** exercises the power-down watchdog.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIOS = 6;
  localparam int CODE_W     = $clog2(NUM_RATIOS);

  typedef logic [CODE_W-1:0] ratio_code_t;

  // Supported master-clock cycles per word-clock period, ascending.
  function automatic int ratio_of(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      default: return 768;
    endcase
  endfunction
endpackage

// File: rtl/wclk_edge_sync.sv
module wclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  // Edge found one stage past the synchroniser output.
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int CNT_W = 10,
  parameter int SAT   = 777
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic [CNT_W-1:0] period,
  output logic             stalled
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  // Starts saturated so the first edge after reset yields no match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= SAT_V;
    else if (rise)          cnt <= ONE_V;
    else if (cnt != SAT_V)  cnt <= cnt + ONE_V;
  end

  assign period  = cnt;
  assign stalled = (cnt == SAT_V) && !rise;
endmodule

// File: rtl/ratio_matcher.sv
module ratio_matcher
  import mrd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 8
) (
  input  logic [CNT_W-1:0] period,
  output logic             hit,
  output ratio_code_t      code
);
  logic [NUM_RATIOS-1:0] in_win;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam int LO = ratio_of(i) - TOL;
    localparam int HI = ratio_of(i) + TOL;
    assign in_win[i] = (int'(period) >= LO) && (int'(period) <= HI);
  end

  always_comb begin
    hit  = |in_win;
    code = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (in_win[i]) code = ratio_code_t'(i);
    end
  end
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
  import mrd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        period_stb,
  input  logic        hit,
  input  ratio_code_t code,
  input  logic        stalled,
  output ratio_code_t ratio_code,
  output logic        locked,
  output logic        mute
);
  ratio_code_t cand;
  logic        cand_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand       <= '0;
      cand_ok    <= 1'b0;
      ratio_code <= '0;
      locked     <= 1'b0;
      mute       <= 1'b1;
    end else if (stalled || (period_stb && !hit)) begin
      cand_ok <= 1'b0;
      locked  <= 1'b0;
      mute    <= 1'b1;
    end else if (period_stb) begin
      cand    <= code;
      cand_ok <= 1'b1;
      if (cand_ok && cand == code) begin
        ratio_code <= code;
        locked     <= 1'b1;
        mute       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clk_stop_watchdog.sv
module clk_stop_watchdog #(
  parameter int WD_W   = 16,
  parameter int STAGES = 2
) (
  input  logic            mclk,
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic [WD_W-1:0] limit,
  output logic            pwr_down
);
  localparam logic [WD_W-1:0] IDLE_MAX = '1;

  logic            tog;
  logic [STAGES:0] sh;
  logic [WD_W-1:0] idle;
  logic            seen;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], tog};
  end

  assign seen = sh[STAGES-1] ^ sh[STAGES];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      idle     <= '0;
      pwr_down <= 1'b0;
    end else begin
      if (seen)                  idle <= '0;
      else if (idle != IDLE_MAX) idle <= idle + WD_W'(1);
      pwr_down <= !seen && (idle >= limit);
    end
  end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TOL       = 8,
  parameter int WD_W      = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic            mclk,
  input  logic            rst_n,
  input  logic            word_clk,
  input  logic            ref_clk,
  input  logic [WD_W-1:0] stop_limit,
  output logic [2:0]      ratio_code,
  output logic            locked,
  output logic            mute,
  output logic            pwr_down
);
  localparam int SAT_COUNT = ratio_of(NUM_RATIOS - 1) + TOL + 1;

  logic             rise;
  logic [CNT_W-1:0] period;
  logic             stalled;
  logic             hit;
  ratio_code_t      code;
  ratio_code_t      code_q;

  wclk_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(mclk), .rst_n(rst_n), .async_in(word_clk), .rise(rise)
  );

  period_counter #(.CNT_W(CNT_W), .SAT(SAT_COUNT)) u_cnt (
    .clk(mclk), .rst_n(rst_n), .rise(rise), .period(period), .stalled(stalled)
  );

  ratio_matcher #(.CNT_W(CNT_W), .TOL(TOL)) u_match (
    .period(period), .hit(hit), .code(code)
  );

  lock_tracker u_lock (
    .clk(mclk), .rst_n(rst_n), .period_stb(rise), .hit(hit), .code(code),
    .stalled(stalled), .ratio_code(code_q), .locked(locked), .mute(mute)
  );

  clk_stop_watchdog #(.WD_W(WD_W), .STAGES(SYNC_STGS)) u_wd (
    .mclk(mclk), .ref_clk(ref_clk), .rst_n(rst_n), .limit(stop_limit),
    .pwr_down(pwr_down)
  );

  assign ratio_code = 3'(code_q);
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
  parameter int CNT_W = 10,
  parameter int SAT   = 777
) (
  input logic             clk,
  input logic             rst_n,
  input logic             locked,
  input logic             mute,
  input logic [2:0]       ratio_code,
  input logic             stalled,
  input logic [CNT_W-1:0] count
);
  AST_LOCK_EXCLUDES_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && mute));                                           // R8
  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_code <= 3'd5);                                          // R8
  AST_CODE_CHANGE_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_code) |-> locked);                             // R5
  AST_UNMUTE_WITH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> locked);                                      // R5
  AST_STALL_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> (mute && !locked));                               // R7
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= SAT);                                          // R7
endmodule

bind mclk_ratio_detect mrd_checker #(.CNT_W(CNT_W), .SAT(SAT_COUNT)) u_chk (
  .clk(mclk), .rst_n(rst_n), .locked(locked), .mute(mute),
  .ratio_code(ratio_code), .stalled(stalled), .count(period)
);

// File: tb/mclk_ratio_detect_test.sv
module mclk_ratio_detect_test;
  logic        mclk = 1'b0;
  logic        mclk_en = 1'b1;
  logic        ref_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_clk = 1'b0;
  logic [15:0] stop_limit = 16'd20;
  logic [2:0]  ratio_code;
  logic        locked, mute, pwr_down;

  int checks = 0;
  int fails  = 0;

  always begin #2.5; if (mclk_en) mclk = ~mclk; end   // 200 MHz
  always #18.5 ref_clk = ~ref_clk;

  mclk_ratio_detect uut (
    .mclk(mclk), .rst_n(rst_n), .word_clk(word_clk), .ref_clk(ref_clk),
    .stop_limit(stop_limit), .ratio_code(ratio_code), .locked(locked),
    .mute(mute), .pwr_down(pwr_down)
  );

  // period, expected locked, expected code, expected mute
  localparam int NV = 15;
  localparam int VEC [NV][4] = '{
    '{128, 1, 0, 0}, '{136, 1, 0, 0}, '{137, 0, 0, 1}, '{120, 1, 0, 0},
    '{119, 0, 0, 1}, '{192, 1, 1, 0}, '{200, 1, 1, 0}, '{256, 1, 2, 0},
    '{300, 0, 0, 1}, '{384, 1, 3, 0}, '{376, 1, 3, 0}, '{512, 1, 4, 0},
    '{520, 1, 4, 0}, '{768, 1, 5, 0}, '{776, 1, 5, 0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic gen_period(input int n);
    word_clk <= 1'b1;
    repeat (n / 2) @(negedge mclk);
    word_clk <= 1'b0;
    repeat (n - n / 2) @(negedge mclk);
  endtask

  initial begin
    #900us;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge mclk);
    check("R1 mute in reset", int'(mute), 1);
    check("R1 locked in reset", int'(locked), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge mclk);
    check("R1 mute", int'(mute), 1);
    check("R1 locked", int'(locked), 0);
    check("R1 code", int'(ratio_code), 0);
    check("R1 pwr_down", int'(pwr_down), 0);

    // R2 R3 table walk
    for (int v = 0; v < NV; v++) begin
      repeat (4) gen_period(VEC[v][0]);
      check($sformatf("R2/R3 locked p=%0d", VEC[v][0]), int'(locked), VEC[v][1]);
      check($sformatf("R2/R3 mute p=%0d", VEC[v][0]), int'(mute), VEC[v][3]);
      if (VEC[v][1] == 1)
        check($sformatf("R2 code p=%0d", VEC[v][0]), int'(ratio_code), VEC[v][2]);
    end

    // R7: hold word clock low
    repeat (800) @(negedge mclk);
    check("R7 mute after stall", int'(mute), 1);
    check("R7 locked after stall", int'(locked), 0);

    // R5: one good period is not enough
    gen_period(256);
    word_clk <= 1'b1;
    repeat (20) @(negedge mclk);
    check("R5 mute after one period", int'(mute), 1);
    check("R5 locked after one period", int'(locked), 0);
    repeat (108) @(negedge mclk);
    word_clk <= 1'b0;
    repeat (128) @(negedge mclk);
    word_clk <= 1'b1;
    repeat (20) @(negedge mclk);
    check("R5 locked after two periods", int'(locked), 1);
    check("R5 mute after two periods", int'(mute), 0);
    check("R5 code after two periods", int'(ratio_code), 2);
    repeat (108) @(negedge mclk);
    word_clk <= 1'b0;
    repeat (128) @(negedge mclk);

    // R4: one bad period while locked
    gen_period(256);
    gen_period(300);
    word_clk <= 1'b1;
    repeat (20) @(negedge mclk);
    check("R4 mute after bad period", int'(mute), 1);
    check("R4 locked after bad period", int'(locked), 0);
    repeat (106) @(negedge mclk);
    word_clk <= 1'b0;
    repeat (126) @(negedge mclk);

    // R6: jitter inside the 256 window
    for (int k = 0; k < 6; k++) begin
      gen_period(252);
      gen_period(260);
    end
    check("R6 locked under jitter", int'(locked), 1);
    check("R6 code under jitter", int'(ratio_code), 2);
    check("R6 mute under jitter", int'(mute), 0);

    // R9: master clock stop watchdog
    check("R9 pwr_down while running", int'(pwr_down), 0);
    mclk_en = 1'b0;
    repeat (40) @(negedge ref_clk);
    check("R9 pwr_down after stop", int'(pwr_down), 1);
    mclk_en = 1'b1;
    repeat (10) @(negedge ref_clk);
    check("R9 pwr_down after restart", int'(pwr_down), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule